// File: doc/BRIEF.md
# Sensor Packet Framer with CRC8

This block turns one sensor sample into a short, fixed-length radio payload. A one-cycle start strobe captures a 16-bit temperature word and a 16-bit humidity word. The block then emits a byte stream over a valid/ready handshake. The stream has three parts. Two sync bytes come first. Then comes the payload: the temperature word followed by the humidity word, each split into two bytes. The frame closes with a CRC8 over the four payload bytes, which the block accumulates as those bytes are accepted.

A downstream serializer or radio driver pulls the bytes at its own pace. A last flag marks the checksum byte. A one-cycle completion pulse follows acceptance of that byte, so the sensor sequencer knows when it can start another sample.

Top module: `pktFramer`

## Requirements
- R1: While reset is asserted, and right after it is released, `outValid`, `outLast` and `doneOut` are low.
- R2: A `startIn` pulse while idle raises `outValid` in the next cycle. The first two frame bytes are each 0xAA.
- R3: Bytes 3 to 6 of the frame are, in this order: temperature bits 15:8, temperature bits 7:0, humidity bits 15:8, humidity bits 7:0.
- R4: Byte 7 is a CRC8 over bytes 3 to 6. It uses polynomial 0x07, starts from 0x00, shifts MSB first, is not reflected and has no final XOR.
- R5: While `outValid` is high and `outReady` is low, the next cycle still has `outValid` high and `outData` unchanged.
- R6: `outLast` is high only while byte 7 (the CRC byte) is presented. A frame is exactly seven bytes, well inside a 255-byte packet limit.
- R7: `doneOut` is high for exactly one cycle, the cycle after the CRC byte is accepted. `outValid` is low in that cycle.
- R8: `startIn` while a frame is in progress has no effect. The input words are sampled only on an accepted start, so later changes do not alter the frame.
- R9: A start presented in the cycle after the CRC byte is accepted begins a new frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe, samples the input words when idle |
| tempIn | input | 16 | Temperature sample word |
| humIn | input | 16 | Humidity sample word |
| outData | output | 8 | Current frame byte |
| outValid | output | 1 | `outData` holds a frame byte |
| outReady | input | 1 | Sink accepts the byte when high together with `outValid` |
| outLast | output | 1 | Current byte is the CRC byte |
| doneOut | output | 1 | One-cycle pulse after the CRC byte is accepted |

## Verification
A wrong byte index shows on `outData` in the first cycle that index is presented: a wrong sync byte, a swapped payload byte, or a last flag on the wrong position. A stalled index shows as a frame longer than seven bytes and a missing `doneOut`. A corrupted CRC register shows only in the seventh byte, so every frame is compared in full, with payloads that exercise all bit positions. The bench also holds `outReady` low at random to expose updates that happen without a handshake. A busy flag that clears too early shows as a restarted frame after a mid-frame start.

// File: rtl/framerPkg.sv
package framerPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture sample words, reset checksum
    logic advance;  // current byte accepted by the sink
  } ctlStrobeT;

  // one byte through an MSB-first CRC8, no reflection
  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn,
                                          input logic [7:0] dataIn,
                                          input logic [7:0] poly);
    logic [7:0] acc;
    acc = crcIn ^ dataIn;
    for (int b = 0; b < 8; b++) begin
      acc = acc[7] ? ((acc << 1) ^ poly) : (acc << 1);
    end
    return acc;
  endfunction

endpackage

// File: rtl/framerCtl.sv
module framerCtl
  import framerPkg::*;
#(
  parameter int FRAME_LEN = 7,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             outReady,
  output logic             outValid,
  output logic             outLast,
  output logic             doneOut,
  output logic [IDX_W-1:0] byteIdx,
  output ctlStrobeT        strobe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic busy;
  logic doneR;
  logic [IDX_W-1:0] idxR;
  logic fire;
  logic atLast;

  assign fire   = busy && outReady;
  assign atLast = (idxR == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      doneR <= 1'b0;
      idxR  <= '0;
    end else begin
      doneR <= fire && atLast;
      if (fire) begin
        if (atLast) busy <= 1'b0;
        else        idxR <= idxR + 1'b1;
      end else if (startIn && !busy) begin
        busy <= 1'b1;
        idxR <= '0;
      end
    end
  end

  assign outValid       = busy;
  assign outLast        = busy && atLast;
  assign doneOut        = doneR;
  assign byteIdx        = idxR;
  assign strobe.load    = startIn && !busy;
  assign strobe.advance = fire;

endmodule

// File: rtl/framerDp.sv
module framerDp
  import framerPkg::*;
#(
  parameter int         PRE_LEN  = 2,
  parameter logic [7:0] PRE_BYTE = 8'hAA,
  parameter logic [7:0] CRC_POLY = 8'h07,
  parameter logic [7:0] CRC_INIT = 8'h00,
  parameter int         IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobeT        strobe,
  input  logic [IDX_W-1:0] byteIdx,
  input  logic [15:0]      tempIn,
  input  logic [15:0]      humIn,
  output logic [7:0]       outData
);

  localparam int PAY_LEN = 4;
  localparam int PAY_END = PRE_LEN + PAY_LEN;

  logic [8*PAY_LEN-1:0] payWord;
  logic [7:0] crcR;
  logic [7:0] curByte;
  logic [1:0] slot;
  logic inPre;
  logic inPay;

  assign inPre = int'(byteIdx) < PRE_LEN;
  assign inPay = !inPre && (int'(byteIdx) < PAY_END);
  assign slot  = 2'(int'(byteIdx) - PRE_LEN);

  always_comb begin
    if (inPre)      curByte = PRE_BYTE;
    else if (inPay) curByte = payWord[8*(PAY_LEN-1-int'(slot)) +: 8];
    else            curByte = crcR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      payWord <= '0;
      crcR    <= CRC_INIT;
    end else if (strobe.load) begin
      payWord <= {tempIn, humIn};
      crcR    <= CRC_INIT;
    end else if (strobe.advance && inPay) begin
      crcR    <= crc8Step(crcR, curByte, CRC_POLY);
    end
  end

  assign outData = curByte;

endmodule

// File: rtl/pktFramer.sv
module pktFramer
  import framerPkg::*;
#(
  parameter int         PRE_LEN  = 2,
  parameter logic [7:0] PRE_BYTE = 8'hAA,
  parameter logic [7:0] CRC_POLY = 8'h07,
  parameter logic [7:0] CRC_INIT = 8'h00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic [15:0] tempIn,
  input  logic [15:0] humIn,
  output logic [7:0]  outData,
  output logic        outValid,
  input  logic        outReady,
  output logic        outLast,
  output logic        doneOut
);

  localparam int FRAME_LEN = PRE_LEN + 4 + 1;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  ctlStrobeT        strobe;
  logic [IDX_W-1:0] byteIdx;

  framerCtl #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) uCtl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .outReady(outReady),
    .outValid(outValid), .outLast(outLast), .doneOut(doneOut),
    .byteIdx(byteIdx), .strobe(strobe)
  );

  framerDp #(.PRE_LEN(PRE_LEN), .PRE_BYTE(PRE_BYTE), .CRC_POLY(CRC_POLY),
             .CRC_INIT(CRC_INIT), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteIdx(byteIdx),
    .tempIn(tempIn), .humIn(humIn), .outData(outData)
  );

endmodule

// File: rtl/framerChk.sv
module framerChk #(
  parameter logic [7:0] PRE_BYTE  = 8'hAA,
  parameter int         FRAME_LEN = 7
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outReady,
  input logic       outLast,
  input logic       doneOut
);

  logic [8:0] acceptCnt;

  always_ff @(posedge clk) begin
    if (!rstN) acceptCnt <= '0;
    else if (outValid && outReady) acceptCnt <= outLast ? 9'd0 : acceptCnt + 9'd1;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData)); // R5

  AST_FIRST_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outData == PRE_BYTE); // R2

  AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid && acceptCnt == 9'(FRAME_LEN - 1)); // R6

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> doneOut && !outValid); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R7

endmodule

bind pktFramer framerChk #(.PRE_BYTE(PRE_BYTE), .FRAME_LEN(FRAME_LEN)) uChk (
  .clk(clk), .rstN(rstN), .outData(outData), .outValid(outValid),
  .outReady(outReady), .outLast(outLast), .doneOut(doneOut)
);

// File: tb/sim_pktFramer.sv
module sim_pktFramer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [15:0] tempIn = '0;
  logic [15:0] humIn = '0;
  logic outReady = 1'b0;
  logic [7:0] outData;
  logic outValid, outLast, doneOut;

  pktFramer u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .tempIn(tempIn), .humIn(humIn),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .outLast(outLast), .doneOut(doneOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference checksum, bit-serial form
  function automatic logic [7:0] refCrc(input logic [31:0] bytesIn);
    logic [7:0] c = 8'h00;
    for (int k = 31; k >= 0; k--) begin
      logic fb;
      fb = c[7] ^ bytesIn[k];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  // reference model
  logic [7:0] q[$];
  bit refBusy = 0, refDone = 0, holdPend = 0;
  int refPos = 0;
  logic [7:0] holdData;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); refBusy = 0; refDone = 0; refPos = 0; holdPend = 0;
    end else begin
      refDone = 0;
      holdPend = outValid && !outReady;
      holdData = outData;
      if (refBusy) begin
        if (outReady) begin
          void'(q.pop_front());
          refPos++;
          if (q.size() == 0) begin refBusy = 0; refDone = 1; end
        end
      end else if (startIn) begin
        q = {8'hAA, 8'hAA, tempIn[15:8], tempIn[7:0], humIn[15:8], humIn[7:0],
             refCrc({tempIn, humIn})};
        refBusy = 1; refPos = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(outValid == refBusy, "R2 R8 R9 valid", outValid, refBusy);
      check(doneOut == refDone, "R7 done", doneOut, refDone);
      if (refBusy && q.size() > 0) begin
        if (refPos < 2)      check(outData == q[0], "R2 sync byte", outData, q[0]);
        else if (refPos < 6) check(outData == q[0], "R3 payload byte", outData, q[0]);
        else                 check(outData == q[0], "R4 crc byte", outData, q[0]);
        check(outLast == (q.size() == 1), "R6 last", outLast, q.size() == 1);
      end else begin
        check(outLast == 1'b0, "R6 last idle", outLast, 0);
      end
      if (holdPend) check(outData == holdData, "R5 hold", outData, holdData);
    end
  end

  task automatic startFrame(input logic [15:0] t, input logic [15:0] h);
    @(negedge clk); tempIn = t; humIn = h; startIn = 1'b1;
    @(negedge clk); startIn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && !outLast && !doneOut, "R1 in reset", {outValid, outLast, doneOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !outLast && !doneOut, "R1 after reset", {outValid, outLast, doneOut}, 0);

    // plain frame, sink always ready
    outReady = 1'b1;
    startFrame(16'h1234, 16'h5678);
    repeat (10) @(negedge clk);

    // extreme payloads
    startFrame(16'h0000, 16'h0000);
    repeat (9) @(negedge clk);
    startFrame(16'hFFFF, 16'hFFFF);
    repeat (9) @(negedge clk);
    startFrame(16'h8001, 16'h00FF);
    // R8: start and input changes mid-frame
    @(negedge clk); tempIn = 16'hDEAD; humIn = 16'hBEEF; startIn = 1'b1;
    @(negedge clk); startIn = 1'b0;
    repeat (8) @(negedge clk);

    // R9: start held high, frames back to back
    tempIn = 16'hA5C3; humIn = 16'h3C5A; startIn = 1'b1;
    repeat (30) @(negedge clk);
    startIn = 1'b0;
    repeat (10) @(negedge clk);

    // random sink stalls, random starts and inputs
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      outReady = ($urandom % 3) != 0;
      tempIn   = 16'($urandom);
      humIn    = 16'($urandom);
      startIn  = ($urandom % 4) == 0;
    end
    startIn = 1'b0; outReady = 1'b1;
    repeat (12) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule